// File: doc/BRIEF.md
# Three-Wire Configuration Register Bank

This block takes configuration words from a three-line serial bus: a bit clock, a data line and a strobe. It stores them in two working registers. The bus lines are brought into the system clock domain through synchronizers, and their edges are detected there. While the strobe is low, each rising edge of the bit clock shifts one data bit into a shift register. When the strobe rises, the block examines the collected word. A word is accepted only if all three of these hold:
- exactly 21 bits arrived;
- the four leading bits carry the chip address;
- for the synthesizer word, the divider value is legal.

A flag bit that follows the address steers an accepted word to one of the two working registers.

The first working register drives the synthesizer settings: main divider ratio, reference divider select, charge-pump current code and test bits. The second drives the receive gain controls: a serial gain code, a bit that chooses where the gain comes from, and the enable for the 2.5 V reference regulator. A registered multiplexer presents either six external gain pins or the serial gain code to the amplifier. The reference enable output is active only while the transmitter enable input is also high. Every working register starts from a fixed default after reset.

Top module: `cfg3w_bank`

## Requirements
- R1: After reset the outputs hold these defaults:
  - `ndiv_o`=352;
  - `rsel_o`=2'b10 (divide by 22);
  - `cp_code_o`=3'b111;
  - `test_o`=2'b00;
  - serial gain code 6'b111111;
  - `gain_sel_o`=0;
  - regulator enable bit 1, so `vref_en_o` equals `tx_en_i`.
- R2: Data is shifted only while the strobe is low, on rising edges of the bit clock, and the first bit sent becomes the most significant bit of the 21-bit word.
- R3: A word whose leading four bits are 1,1,1,0 followed by flag 0 loads the synthesizer register. The remaining bits arrive in this order:
  - nine divider bits, most significant first, to `ndiv_o`;
  - r0,r1 to `rsel_o`={r0,r1};
  - c0,c1,c2 to `cp_code_o`={c2,c1,c0};
  - x0,x1 to `test_o`={x0,x1}.
  The gain register is not touched.
- R4: A word with address 1,1,1,0 and flag 1 loads the gain register. Its bits arrive in this order:
  - eight unused bits, which are ignored;
  - gain bits b0..b5, with b0 as bit 0 of the code;
  - the source bit bc;
  - the regulator bit vc.
  The synthesizer register is not touched.
- R5: Working registers change only after a strobe rising edge. A complete word whose strobe has not yet risen changes no output.
- R6: `gain_o` equals `gain_pin_i` (pin GC0 on bit 0) when bc=0, and the serial gain code when bc=1. `gain_sel_o` shows bc.
- R7: `vref_en_o` is high only when vc=1 and `tx_en_i` is high.
- R8: A word whose address bits differ from 1,1,1,0 changes no working register.
- R9: A word of 20 or of 22 bits before the strobe rises changes no working register.
- R10: A synthesizer word with a divider below 64 is discarded whole. The values 64 and 511 are accepted.
- R11: Bus operation is correct at a bit-clock rate of 10 MHz against a 200 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_dat_i | input | 1 | Serial data |
| ser_stb_i | input | 1 | Serial strobe; low while shifting, rising edge transfers |
| gain_pin_i | input | 6 | External gain code pins, GC0 on bit 0 |
| tx_en_i | input | 1 | Transmitter enable |
| ndiv_o | output | 9 | Main divider ratio |
| rsel_o | output | 2 | Reference divider select {r0,r1} |
| cp_code_o | output | 3 | Charge-pump current code {c2,c1,c0} |
| test_o | output | 2 | Test bits {x0,x1} |
| gain_o | output | 6 | Gain code presented to the amplifier |
| gain_sel_o | output | 1 | Gain source: 0 pins, 1 serial |
| vref_en_o | output | 1 | 2.5 V reference enable |

## Verification
The bench targets the places where a faulty design would quietly drop or misplace settings:
- Words that are one bit short or one bit long are sent. A counter that does not check the length would latch the last 21 bits and overwrite the settings.
- Wrong addresses and a divider of 63 are sent. Missing checks would let either one corrupt the divider or the gain.
- Every field gets distinct, asymmetric values, so a reversed bit order in the charge-pump or gain field shows up as a different code.
- The outputs are checked before the strobe rises, to catch a design that transfers early.
- The source bit and the transmit enable are toggled, to catch a multiplexer that picks the wrong side or a reference enable that ignores the transmitter.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int WORD_W    = 21;
  localparam int ADDR_W    = 4;
  localparam int PAY_W     = WORD_W - ADDR_W - 1;
  localparam logic [ADDR_W-1:0] CHIP_ADDR = 4'b1110;
  localparam int N_W       = 9;
  localparam int N_MIN     = 64;
  localparam int RS_W      = 2;
  localparam int CP_W      = 3;
  localparam int TS_W      = 2;
  localparam int G_W       = 6;
  localparam int SPARE_W   = PAY_W - G_W - 2;

  typedef struct packed {
    logic [N_W-1:0]  ndiv;
    logic [RS_W-1:0] rsel;
    logic [CP_W-1:0] cp;
    logic [TS_W-1:0] tst;
  } synth_cfg_t;

  typedef struct packed {
    logic [G_W-1:0] gain;
    logic           bc;
    logic           vc;
  } gain_cfg_t;

  localparam synth_cfg_t SYNTH_DEF = '{ndiv: 9'd352, rsel: 2'b10, cp: 3'b111, tst: 2'b00};
  localparam gain_cfg_t  GAIN_DEF  = '{gain: 6'b111111, bc: 1'b0, vc: 1'b1};
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= stg[k-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              sstb_i,
  output logic [WORD_W-1:0] word_o,
  output logic              evt_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic             sclk_p, sstb_p;
  logic [CNT_W-1:0] cnt;
  logic             sclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= 1'b0;
      sstb_p <= 1'b0;
    end else begin
      sclk_p <= sclk_i;
      sstb_p <= sstb_i;
    end
  end

  assign sclk_rise = sclk_i & ~sclk_p;
  assign evt_o     = sstb_i & ~sstb_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      cnt    <= '0;
    end else if (evt_o) begin
      cnt <= '0;
    end else if (sclk_rise && !sstb_i) begin
      word_o <= {word_o[WORD_W-2:0], sdat_i};
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  assign full_o = (cnt == CNT_W'(WORD_W));
endmodule

// File: rtl/cfg3w_regs.sv
module cfg3w_regs
  import cfg3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] word_i,
  output synth_cfg_t        synth_o,
  output gain_cfg_t         gain_o
);
  localparam int SA_BIT = PAY_W;
  localparam int RS_LO  = PAY_W - N_W - RS_W;
  localparam int CP_LO  = RS_LO - CP_W;
  localparam int G_LO   = 2;

  logic       addr_ok, sa;
  synth_cfg_t synth_nx;
  gain_cfg_t  gain_nx;

  assign addr_ok = (word_i[WORD_W-1 -: ADDR_W] == CHIP_ADDR);
  assign sa      = word_i[SA_BIT];

  always_comb begin
    synth_nx.ndiv = word_i[PAY_W-1 -: N_W];
    synth_nx.rsel = word_i[RS_LO +: RS_W];
    for (int i = 0; i < CP_W; i++) synth_nx.cp[i] = word_i[CP_LO + CP_W - 1 - i];
    synth_nx.tst  = word_i[TS_W-1:0];
    for (int i = 0; i < G_W; i++) gain_nx.gain[i] = word_i[G_LO + G_W - 1 - i];
    gain_nx.bc = word_i[1];
    gain_nx.vc = word_i[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synth_o <= SYNTH_DEF;
      gain_o  <= GAIN_DEF;
    end else if (evt_i && full_i && addr_ok) begin
      if (!sa && synth_nx.ndiv >= N_W'(N_MIN)) synth_o <= synth_nx;
      if (sa) gain_o <= gain_nx;
    end
  end
endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank
  import cfg3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_stb_i,
  input  logic [G_W-1:0] gain_pin_i,
  input  logic           tx_en_i,
  output logic [N_W-1:0] ndiv_o,
  output logic [RS_W-1:0] rsel_o,
  output logic [CP_W-1:0] cp_code_o,
  output logic [TS_W-1:0] test_o,
  output logic [G_W-1:0] gain_o,
  output logic           gain_sel_o,
  output logic           vref_en_o
);
  logic [2:0]        bus_s;
  logic [WORD_W-1:0] word;
  logic              stb_evt, word_full;
  synth_cfg_t        synth_q;
  gain_cfg_t         gain_q;

  cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk), .rst (rst),
    .d_i ({ser_stb_i, ser_dat_i, ser_clk_i}),
    .q_o (bus_s)
  );

  cfg3w_shift #(.WORD_W(WORD_W)) i_shift (
    .clk (clk), .rst (rst),
    .sclk_i (bus_s[0]), .sdat_i (bus_s[1]), .sstb_i (bus_s[2]),
    .word_o (word), .evt_o (stb_evt), .full_o (word_full)
  );

  cfg3w_regs i_regs (
    .clk (clk), .rst (rst),
    .evt_i (stb_evt), .full_i (word_full), .word_i (word),
    .synth_o (synth_q), .gain_o (gain_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ndiv_o     <= SYNTH_DEF.ndiv;
      rsel_o     <= SYNTH_DEF.rsel;
      cp_code_o  <= SYNTH_DEF.cp;
      test_o     <= SYNTH_DEF.tst;
      gain_o     <= gain_pin_i;
      gain_sel_o <= GAIN_DEF.bc;
      vref_en_o  <= 1'b0;
    end else begin
      ndiv_o     <= synth_q.ndiv;
      rsel_o     <= synth_q.rsel;
      cp_code_o  <= synth_q.cp;
      test_o     <= synth_q.tst;
      gain_o     <= gain_q.bc ? gain_q.gain : gain_pin_i;
      gain_sel_o <= gain_q.bc;
      vref_en_o  <= gain_q.vc & tx_en_i;
    end
  end
endmodule

// File: rtl/cfg3w_chk.sv
module cfg3w_chk
  import cfg3w_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           tx_en_i,
  input logic           vref_en_o,
  input logic [G_W-1:0] gain_pin_i,
  input logic [G_W-1:0] gain_o,
  input logic [N_W-1:0] ndiv_o,
  input logic           stb_evt,
  input synth_cfg_t     synth_q,
  input gain_cfg_t      gain_q
);
  // R5: working registers move only on a strobe event
  a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !stb_evt |=> ($stable(synth_q) && $stable(gain_q)));

  // R6: pin path when bc=0
  a_r6_pin_source: assert property (@(posedge clk) disable iff (rst)
    !gain_q.bc |=> (gain_o == $past(gain_pin_i)));

  // R6: serial path when bc=1
  a_r6_reg_source: assert property (@(posedge clk) disable iff (rst)
    gain_q.bc |=> (gain_o == $past(gain_q.gain)));

  // R7: reference enable requires transmit
  a_r7_vref_needs_tx: assert property (@(posedge clk) disable iff (rst)
    !tx_en_i |=> !vref_en_o);

  // R10: divider never below the legal floor
  a_r10_ndiv_floor: assert property (@(posedge clk) disable iff (rst)
    ndiv_o >= N_W'(N_MIN));
endmodule

bind cfg3w_bank cfg3w_chk i_chk (
  .clk (clk), .rst (rst), .tx_en_i (tx_en_i), .vref_en_o (vref_en_o),
  .gain_pin_i (gain_pin_i), .gain_o (gain_o), .ndiv_o (ndiv_o),
  .stb_evt (stb_evt), .synth_q (synth_q), .gain_q (gain_q)
);

// File: tb/test_cfg3w_bank.sv
`timescale 1ns/100ps
module test_cfg3w_bank;
  localparam int HALF = 10; // 10 MHz bit clock against 200 MHz (R11)

  logic clk = 0, rst = 1;
  logic sclk = 0, sdat = 0, sstb = 0, tx = 0;
  logic [5:0] gp = 6'h00;
  logic [8:0] ndiv; logic [1:0] rsel; logic [2:0] cp; logic [1:0] tst;
  logic [5:0] gain; logic gsel, vref;

  always #2.5 clk = ~clk;

  cfg3w_bank i_cfg3w_bank (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_stb_i(sstb),
    .gain_pin_i(gp), .tx_en_i(tx), .ndiv_o(ndiv), .rsel_o(rsel), .cp_code_o(cp),
    .test_o(tst), .gain_o(gain), .gain_sel_o(gsel), .vref_en_o(vref)
  );

  int total = 0, bad = 0, cyc = 0, hold_until = 12;
  int e_n = 352, e_rs = 2, e_cp = 7, e_ts = 0, e_g = 63, e_bc = 0, e_vc = 1;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all(input string why);
    check({"R3 ndiv ", why}, ndiv, e_n);
    check({"R3 rsel ", why}, rsel, e_rs);
    check({"R3 cp ", why}, cp, e_cp);
    check({"R3 test ", why}, tst, e_ts);
    check({"R6 gain ", why}, gain, e_bc ? e_g : gp);
    check({"R6 gsel ", why}, gsel, e_bc);
    check({"R7 vref ", why}, vref, e_vc & tx);
  endtask

  function automatic logic [20:0] w1(input logic [3:0] a, input int n, input logic [1:0] rs,
                                     input logic [2:0] c, input logic [1:0] x);
    logic [8:0] nn = n[8:0];
    return {a, 1'b0, nn, rs, c[0], c[1], c[2], x};
  endfunction

  function automatic logic [20:0] w2(input logic [5:0] g, input logic bc, input logic vc);
    return {4'b1110, 1'b1, 8'hA5, g[0], g[1], g[2], g[3], g[4], g[5], bc, vc};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R2: first bit sent first; R5: outputs checked before strobe
  task automatic send(input int nb, input logic [31:0] v, input string tag);
    for (int i = nb - 1; i >= 0; i--) begin
      tick(1); sdat = v[i];
      tick(HALF); sclk = 1;
      tick(HALF); sclk = 0;
    end
    tick(HALF);
    compare_all({"R5 pre-strobe ", tag});
    sstb = 1;
    hold_until = cyc + 12;
    if (nb == 21 && v[20:17] == 4'b1110) begin
      if (!v[16] && v[15:7] >= 64) begin
        e_n = v[15:7]; e_rs = v[6:5]; e_cp = {v[2], v[3], v[4]}; e_ts = v[1:0];
      end
      if (v[16]) begin
        e_g = {v[2], v[3], v[4], v[5], v[6], v[7]}; e_bc = v[1]; e_vc = v[0];
      end
    end
    tick(2 * HALF); sstb = 0;
    tick(HALF);
    compare_all(tag);
  endtask

  task automatic set_pins(input logic [5:0] p, input logic t);
    gp = p; tx = t; hold_until = cyc + 4; tick(6);
  endtask

  initial begin
    fork
      forever begin
        @(negedge clk);
        cyc++;
        if (!rst && cyc > hold_until) compare_all("cycle");
      end
      begin
        tick(5); rst = 0; tick(15);
        compare_all("R1 reset defaults");
        check("R1 vref with tx low", vref, 0);
        set_pins(6'h00, 1);
        check("R1 vref default follows tx", vref, 1);
        set_pins(6'h00, 0);
        send(21, w1(4'b1110, 100, 2'b01, 3'b010, 2'b10), "R3 word1");
        check("R3 ndiv=100", ndiv, 100);
        check("R3 cp reversal", cp, 2);
        check("R4 gain untouched by word1", gsel, 0);
        send(21, w2(6'b001011, 1, 0), "R4 word2");
        check("R4 gain from serial", gain, 11);
        check("R4 ndiv untouched by word2", ndiv, 100);
        set_pins(6'h30, 1);
        check("R7 vc=0 keeps vref low", vref, 0);
        send(21, w2(6'b110100, 1, 1), "R7 vc on");
        check("R7 vc=1 and tx high", vref, 1);
        set_pins(6'h30, 0);
        check("R7 tx low", vref, 0);
        send(21, w2(6'b000001, 0, 1), "R6 pins");
        set_pins(6'h15, 1);
        check("R6 pins 15", gain, 6'h15);
        set_pins(6'h2A, 1);
        check("R6 pins 2A", gain, 6'h2A);
        send(21, w1(4'b1010, 200, 2'b11, 3'b001, 2'b01), "R8 bad address");
        check("R8 ndiv kept", ndiv, 100);
        send(21, {4'b0110, 1'b1, 8'h00, 6'b000000, 1'b1, 1'b0}, "R8 bad address word2");
        check("R8 gsel kept", gsel, 0);
        send(20, {12'h0, w1(4'b1110, 300, 2'b00, 3'b100, 2'b11)} & 32'hFFFFF, "R9 20 bits");
        send(22, {11'h0, 1'b1, w1(4'b1110, 300, 2'b00, 3'b100, 2'b11)}, "R9 22 bits");
        check("R9 ndiv kept", ndiv, 100);
        send(21, w1(4'b1110, 63, 2'b00, 3'b000, 2'b11), "R10 n=63");
        check("R10 n=63 rejected", ndiv, 100);
        check("R10 whole word dropped", tst, 2);
        send(21, w1(4'b1110, 64, 2'b11, 3'b110, 2'b00), "R10 n=64");
        check("R10 n=64", ndiv, 64);
        send(21, w1(4'b1110, 511, 2'b00, 3'b011, 2'b01), "R10 n=511");
        check("R10 n=511", ndiv, 511);
        check("R11 cp at 10MHz bus", cp, 3);
      end
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R11 watchdog actual=timeout expected=finished");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule